// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a word-addressed GPIO controller for up to seven banks of 32 pins each, 224 pins in total. For every pin it keeps a direction bit, an output latch, a rising-edge enable, a falling-edge enable, an edge-status bit and a reporting mask bit. Software reads the synchronized pin levels. It changes output latches only by writing ones to a set register or a clear register. It acknowledges edges by writing ones to the status register.

Banks are interleaved in the address space. Each 256-byte page holds three banks at a 4-byte stride, and each register kind sits at a fixed base offset inside the page. Pin inputs pass through a two-flop synchronizer, and edges are found by comparing the synchronized level with its value one cycle earlier. A single interrupt line is raised while any status bit is set whose mask bit is also set.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset every direction, output latch, edge enable, status and mask bit is 0, so pin_oe is all zeros, pin_out is all zeros and irq is 0.
- R2: Bank n occupies byte offset (n/3)*0x100 + (n%3)*4 added to a kind base. The kind bases are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, mask 0x9C. Bit k of a bank register is pin n*32+k.
- R3: Writing ones to the set register drives the matching output latches high. Writing ones to the clear register drives them low. Zero bits leave the latches unchanged. Reading either address returns the output latch.
- R4: A direction bit of 1 enables the pin driver (pin_oe=1) and 0 makes the pin an input. The level register returns the synchronized pin_in state whatever the direction.
- R5: A low-to-high synchronized transition on a pin with its rising enable set sets its status bit. A high-to-low transition does the same when its falling enable is set. With both enables set, both edges are detected. With an enable clear, that edge sets nothing.
- R6: Writing ones to the status register clears the matching bits. Zero bits leave them unchanged.
- R7: If an enabled edge arrives in the same cycle as a write that clears its status bit, the bit stays set. Other bits cleared by that write still clear.
- R8: irq is 1 exactly when some status bit and its mask bit are both 1. Pending status with mask 0 does not raise irq.
- R9: Reads of unimplemented offsets, of banks at or beyond NUM_BANKS, or of any address not on a 4-byte boundary return 0. Writes to the level register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_in | input | NUM_BANKS*32 | Pad input levels (asynchronous) |
| pin_out | output | NUM_BANKS*32 | Output latches |
| pin_oe | output | NUM_BANKS*32 | Output driver enables (direction) |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
The bench builds the block with its defaults, NUM_BANKS=7 and ADDR_W=10. This brings into reach the third page, where only bank 6 exists and the neighbouring slot at 0x204 must read as zero. The pad model loops each pin's output back onto its input when its driver is enabled, so level reads show output latches and external stimulus side by side. Edge stimulus is timed so that one pin's edge lands in the very cycle of a clearing write.

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
  parameter int NUM_BANKS = 7,
  parameter int ADDR_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NUM_BANKS*32-1:0] pin_in,
  output logic [NUM_BANKS*32-1:0] pin_out,
  output logic [NUM_BANKS*32-1:0] pin_oe,
  output logic                    irq
);
  localparam int NPINS   = NUM_BANKS * 32;
  localparam int OFF_LVL = 'h00;
  localparam int OFF_DIR = 'h0C;
  localparam int OFF_SET = 'h18;
  localparam int OFF_CLR = 'h24;
  localparam int OFF_REN = 'h30;
  localparam int OFF_FEN = 'h3C;
  localparam int OFF_STS = 'h48;
  localparam int OFF_MSK = 'h9C;

  logic [NPINS-1:0] s1, s2, s3;
  logic [NPINS-1:0] dir_q, out_q, ren_q, fen_q, sts_q, msk_q;
  logic [NPINS-1:0] ev;
  logic [31:0]      rd_part [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
    end
  end

  assign ev = (s2 & ~s3 & ren_q) | (~s2 & s3 & fen_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BOFF = (b / 3) * 256 + (b % 3) * 4;
    logic h_lvl, h_dir, h_set, h_clr, h_ren, h_fen, h_sts, h_msk;
    assign h_lvl = (addr == ADDR_W'(OFF_LVL + BOFF));
    assign h_dir = (addr == ADDR_W'(OFF_DIR + BOFF));
    assign h_set = (addr == ADDR_W'(OFF_SET + BOFF));
    assign h_clr = (addr == ADDR_W'(OFF_CLR + BOFF));
    assign h_ren = (addr == ADDR_W'(OFF_REN + BOFF));
    assign h_fen = (addr == ADDR_W'(OFF_FEN + BOFF));
    assign h_sts = (addr == ADDR_W'(OFF_STS + BOFF));
    assign h_msk = (addr == ADDR_W'(OFF_MSK + BOFF));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q[b*32 +: 32] <= '0;
        out_q[b*32 +: 32] <= '0;
        ren_q[b*32 +: 32] <= '0;
        fen_q[b*32 +: 32] <= '0;
        sts_q[b*32 +: 32] <= '0;
        msk_q[b*32 +: 32] <= '0;
      end else begin
        if (wr_en && h_dir) dir_q[b*32 +: 32] <= wdata;
        if (wr_en && h_set) out_q[b*32 +: 32] <= out_q[b*32 +: 32] | wdata;
        if (wr_en && h_clr) out_q[b*32 +: 32] <= out_q[b*32 +: 32] & ~wdata;
        if (wr_en && h_ren) ren_q[b*32 +: 32] <= wdata;
        if (wr_en && h_fen) fen_q[b*32 +: 32] <= wdata;
        if (wr_en && h_msk) msk_q[b*32 +: 32] <= wdata;
        if (wr_en && h_sts)
          sts_q[b*32 +: 32] <= (sts_q[b*32 +: 32] & ~wdata) | ev[b*32 +: 32];
        else
          sts_q[b*32 +: 32] <= sts_q[b*32 +: 32] | ev[b*32 +: 32];
      end
    end

    assign rd_part[b] = ({32{h_lvl}} & s2[b*32 +: 32])
                      | ({32{h_dir}} & dir_q[b*32 +: 32])
                      | ({32{h_set | h_clr}} & out_q[b*32 +: 32])
                      | ({32{h_ren}} & ren_q[b*32 +: 32])
                      | ({32{h_fen}} & fen_q[b*32 +: 32])
                      | ({32{h_sts}} & sts_q[b*32 +: 32])
                      | ({32{h_msk}} & msk_q[b*32 +: 32]);
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata = rdata | rd_part[b];
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(sts_q & msk_q);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !$past(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R1
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out)); // R3
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe)); // R4
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq); // R8
endmodule

// File: tb/sim_gpio_bank_ctl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctl;
  localparam int NB = 7;
  localparam int NP = NB * 32;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pin_ext = '0, pin_in, pin_out, pin_oe;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [9:0]  q_addr [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];
  event smp;

  always #2 clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & pin_ext);

  gpio_bank_ctl #(.NUM_BANKS(NB), .ADDR_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(smp);
    begin
      logic [9:0] a; logic [31:0] e; string t;
      a = q_addr.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      check($sformatf("%s @%h", t, a), rdata, e);
    end
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] e, string t);
    @(negedge clk); addr = a;
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t);
    #1 -> smp;
    #0.5;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pin_ext[31:0] = 32'hA5A5_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    // R1 reset state
    check("R1 pin_oe", pin_oe[31:0], 0);
    check("R1 pin_out", pin_out[31:0], 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(10'h00C, 0, "R1 dir b0");
    rd(10'h048, 0, "R1 sts b0");
    rd(10'h09C, 0, "R1 msk b0");
    // R4 level reads external input while direction is input
    rd(10'h000, 32'hA5A5_0000, "R4 level input");
    // R3 set / clear
    wr(10'h00C, 32'h0000_FFFF);
    check("R4 pin_oe", pin_oe[31:0], 32'h0000_FFFF);
    wr(10'h018, 32'h0000_00F0);
    check("R3 set", pin_out[31:0], 32'h0000_00F0);
    wr(10'h024, 32'h0000_0030);
    check("R3 clear", pin_out[31:0], 32'h0000_00C0);
    rd(10'h018, 32'h0000_00C0, "R3 latch via set addr");
    rd(10'h024, 32'h0000_00C0, "R3 latch via clear addr");
    idle(3);
    rd(10'h000, 32'hA5A5_00C0, "R4 level mixed");
    // latch on an input pin is settable but not driven
    wr(10'h018, 32'h0001_0000);
    check("R4 latch on input", pin_out[31:16], 16'h0001);
    idle(3);
    rd(10'h000, 32'hA5A5_00C0, "R4 input pin ignores latch");
    // R2 interleaved bank addresses
    wr(10'h110, 32'h0000_0003);
    check("R2 bank4 dir", pin_oe[159:128], 3);
    wr(10'h11C, 32'h0000_0002);
    check("R2 bank4 set", pin_out[159:128], 2);
    check("R2 bank3 untouched", pin_out[127:96], 0);
    wr(10'h218, 32'h8000_0000);
    check("R2 bank6 set", pin_out[223:192], 32'h8000_0000);
    wr(10'h008 + 10'h00C, 32'h0000_0100);
    check("R2 bank2 dir", pin_oe[95:64], 32'h100);
    // R9 unimplemented
    rd(10'h204 + 10'h018, 0, "R9 bank7 slot");
    rd(10'h060, 0, "R9 gap offset");
    rd(10'h301, 0, "R9 unaligned/page3");
    rd(10'h019, 0, "R9 unaligned");
    wr(10'h000, 32'hFFFF_FFFF);
    check("R9 level write out", pin_out[31:0], 32'h0001_00C0);
    check("R9 level write oe", pin_oe[31:0], 32'h0000_FFFF);
    // R5 edges on bank 1 (status at 0x04C)
    wr(10'h034, 32'h0000_0001);
    pin_ext[32] = 1; idle(4);
    rd(10'h04C, 32'h1, "R5 rising");
    check("R8 masked irq low", {31'd0, irq}, 0);
    pin_ext[32] = 0; idle(4);
    rd(10'h04C, 32'h1, "R5 falling not enabled");
    wr(10'h0A0, 32'hFFFF_FFFF);
    check("R8 irq unmasked", {31'd0, irq}, 1);
    wr(10'h04C, 32'h1);
    rd(10'h04C, 0, "R6 clear");
    check("R8 irq after clear", {31'd0, irq}, 0);
    // both edges on bit 1
    wr(10'h034, 32'h0000_0003);
    wr(10'h040, 32'h0000_0002);
    pin_ext[33] = 1; idle(4);
    rd(10'h04C, 32'h2, "R5 both rise");
    wr(10'h04C, 32'h2);
    pin_ext[33] = 0; idle(4);
    rd(10'h04C, 32'h2, "R5 both fall");
    // R6 zero bits untouched: bit1 pending, clear bit0 only
    wr(10'h04C, 32'h1);
    rd(10'h04C, 32'h2, "R6 zero bits kept");
    // R7 edge in same cycle as clear: bit0 edge arrives at clear write
    @(negedge clk); pin_ext[32] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 10'h04C; wdata = 32'h3;
    @(negedge clk); wr_en = 0;
    rd(10'h04C, 32'h1, "R7 edge wins");
    check("R8 irq pending", {31'd0, irq}, 1);
    wr(10'h04C, 32'hFFFF_FFFF);
    rd(10'h04C, 0, "R6 clear all");
    check("R8 irq idle", {31'd0, irq}, 0);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule